// File: doc/BRIEF.md
# Load/Store Multi-Cycle Control Sequencer

This block sequences a multi-cycle load/store processor. It moves each instruction through one phase per clock: a shared fetch phase, a shared decode phase, and then a short run of phases chosen by the opcode. After the last phase of a load or a store, it returns to fetch. The block drives every enable and select the datapath needs in each phase. The opcode field of the instruction register is its only data input.

The controller is a Moore machine. A 3-bit state register indexes two separate tables. A narrow next-state table uses the opcode only while the state is decode. A wide output table reads the state alone. The state is also driven out, so that integration and debug can follow the phase sequence.

Top module: `ldst_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is 0 (fetch), whatever the opcode.
- R2: State numbering is fetch=0, decode=1, store-address=2, store-write=3, load-address=4, load-read=5, load-writeback=6. Fetch always goes to decode on the next edge.
- R3: In decode, opcode 43 goes to state 2, opcode 35 goes to state 4, and every other opcode value goes back to state 0.
- R4: The store sequence is unconditional: 2 goes to 3, and 3 goes to 0.
- R5: The load sequence is unconditional: 4 goes to 5, 5 goes to 6, and 6 goes to 0.
- R6: Output encodings are as follows. `alu_a_sel` is 0 for the PC and 1 for holding register A. `alu_b_sel` is 0 for B, 1 for the constant four, and 2 for the sign-extended immediate. `alu_op` is 0 for add. `pc_sel` is 0 for the ALU output. `dst_sel` is 0 for the rt field. `addr_sel` is 0 for the PC and 1 for the result register. In fetch, `pc_we` and `ir_we` are 1 and `alu_b_sel`=1. Every other output is 0.
- R7: In decode, every enable and select output is 0.
- R8: In states 2 and 4, `alu_a_sel`=1 and `alu_b_sel`=2. Every other output is 0.
- R9: In state 3, `mem_we`=1 and `addr_sel`=1. Every other output is 0.
- R10: In state 5, `addr_sel`=1. Every other output is 0.
- R11: In state 6, `rf_we`=1 and `dst_sel`=0. Every other output is 0.
- R12: Outputs depend only on the state. A change of opcode within a cycle leaves every output unchanged, and the opcode has no effect on the next state outside decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| state | output | 3 | Current phase number |
| pc_we | output | 1 | PC write enable |
| ir_we | output | 1 | Instruction register write enable |
| mem_we | output | 1 | Memory write enable |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A select |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU operation |
| pc_sel | output | 1 | PC source select |
| dst_sel | output | 1 | Destination register field select |
| addr_sel | output | 1 | Memory address source select |

## Verification
A wrong state value shows at the ports on the same cycle. The output vector is a pure function of the state, so a wrong phase changes some enable or select at once, and it also appears directly on `state`. A wrong transition out of decode shows one cycle after the decode edge. A sequence that is too short or too long shows as a misplaced `mem_we` or `rf_we`, or as a missing return to fetch, within three cycles. The bench therefore sweeps every one of the 64 opcodes through a full instruction. It compares the whole output vector and the state on every cycle against a reference table.

// File: rtl/ldst_ctrl_fsm.sv
`timescale 1ns/1ps
module ldst_ctrl_fsm #(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_LOAD  = OPW'(35),
  parameter logic [OPW-1:0] OP_STORE = OPW'(43)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [2:0]     state,
  output logic           pc_we,
  output logic           ir_we,
  output logic           mem_we,
  output logic           rf_we,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic           pc_sel,
  output logic           dst_sel,
  output logic           addr_sel
);
  localparam int CW = 12;

  typedef enum logic [2:0] {
    S_FETCH = 3'd0, S_DEC = 3'd1, S_ST_ADR = 3'd2, S_ST_WR = 3'd3,
    S_LD_ADR = 3'd4, S_LD_RD = 3'd5, S_LD_WB = 3'd6
  } phase_t;

  logic [2:0]    cur, nxt;
  logic [CW-1:0] ctl;

  // narrow next-state table
  always_comb begin
    case (cur)
      S_FETCH:  nxt = S_DEC;
      S_DEC:    nxt = (opcode == OP_STORE) ? S_ST_ADR :
                      (opcode == OP_LOAD)  ? S_LD_ADR : S_FETCH;
      S_ST_ADR: nxt = S_ST_WR;
      S_LD_ADR: nxt = S_LD_RD;
      S_LD_RD:  nxt = S_LD_WB;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end

  // wide output table: {pc_we, ir_we, mem_we, rf_we, a_sel, b_sel[2], op[2], pc_sel, dst_sel, addr_sel}
  always_comb begin
    case (cur)
      S_FETCH:            ctl = 12'b1100_0_01_00_0_0_0;
      S_ST_ADR, S_LD_ADR: ctl = 12'b0000_1_10_00_0_0_0;
      S_ST_WR:            ctl = 12'b0010_0_00_00_0_0_1;
      S_LD_RD:            ctl = 12'b0000_0_00_00_0_0_1;
      S_LD_WB:            ctl = 12'b0001_0_00_00_0_0_0;
      default:            ctl = '0;
    endcase
  end

  assign state = cur;
  assign {pc_we, ir_we, mem_we, rf_we, alu_a_sel, alu_b_sel, alu_op,
          pc_sel, dst_sel, addr_sel} = ctl;

  a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> state == 3'd0);
  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    ir_we |=> state == 3'd1);
  a_r3_store_decode: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && opcode == OP_STORE) |=> state == 3'd2);
  a_r3_load_decode: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && opcode == OP_LOAD) |=> state == 3'd4);
  a_r4_store_ends: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> state == 3'd0);
  a_r5_load_ends: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> state == 3'd0);
  a_r9_write_exclusive: assert property (@(posedge clk)
    $onehot0({mem_we, rf_we, ir_we}));
  a_r6_pc_with_ir: assert property (@(posedge clk) pc_we == ir_we);
  a_r12_state_range: assert property (@(posedge clk) disable iff (rst)
    state != 3'd7);
endmodule

// File: tb/ldst_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module ldst_ctrl_fsm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [2:0] state;
  logic pc_we, ir_we, mem_we, rf_we, alu_a_sel, pc_sel, dst_sel, addr_sel;
  logic [1:0] alu_b_sel, alu_op;
  int checks = 0;
  int fails = 0;
  logic [2:0] exp_st;

  always #10 clk = ~clk;

  ldst_ctrl_fsm u_ldst_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .state(state),
    .pc_we(pc_we), .ir_we(ir_we), .mem_we(mem_we), .rf_we(rf_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_sel(pc_sel), .dst_sel(dst_sel), .addr_sel(addr_sel));

  function automatic logic [11:0] ref_out(input logic [2:0] s);
    case (s)
      3'd0:       return {4'b1100, 1'b0, 2'd1, 2'd0, 3'b000};
      3'd2, 3'd4: return {4'b0000, 1'b1, 2'd2, 2'd0, 3'b000};
      3'd3:       return {4'b0010, 1'b0, 2'd0, 2'd0, 3'b001};
      3'd5:       return {4'b0000, 1'b0, 2'd0, 2'd0, 3'b001};
      3'd6:       return {4'b0001, 1'b0, 2'd0, 2'd0, 3'b000};
      default:    return 12'd0;
    endcase
  endfunction

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic [5:0] op);
    case (s)
      3'd0: return 3'd1;
      3'd1: return (op == 6'd43) ? 3'd2 : (op == 6'd35) ? 3'd4 : 3'd0;
      3'd2: return 3'd3;
      3'd4: return 3'd5;
      3'd5: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2, 3'd4: return "R8";
      3'd3: return "R9";
      3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk_outs(input string rq, input logic [2:0] s);
    logic [11:0] got;
    got = {pc_we, ir_we, mem_we, rf_we, alu_a_sel, alu_b_sel, alu_op,
           pc_sel, dst_sel, addr_sel};
    checks++;
    if (got !== ref_out(s)) begin
      fails++;
      $display("FAIL %s state=%0d outputs actual=%b expected=%b", rq, s, got, ref_out(s));
    end
  endtask

  task automatic chk_state(input string rq, input logic [2:0] e);
    checks++;
    if (state !== e) begin
      fails++;
      $display("FAIL %s state actual=%0d expected=%0d", rq, state, e);
    end
  endtask

  // one clock: drive op after the edge, check mid-cycle, wiggle opcode, recheck
  task automatic step(input logic [5:0] op, input bit wiggle);
    @(posedge clk);
    exp_st = rst ? 3'd0 : ref_next(exp_st, opcode);
    #2 opcode = op;
    #6 chk_state(rst ? "R1" : "R2", exp_st);
    chk_outs(req_of(exp_st), exp_st);
    if (wiggle && exp_st != 3'd1) begin
      #2 opcode = op ^ 6'h2A;
      #2 chk_outs("R12", exp_st);
      #1 opcode = op;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_st = 3'd0;
    rst = 1'b1;
    step(6'd43, 1'b0);
    step(6'd35, 1'b0);
    chk_state("R1", 3'd0);
    chk_outs("R1", 3'd0);
    for (int op = 0; op < 64; op++) begin
      rst = 1'b1;
      step(6'(op), 1'b0);
      #2 rst = 1'b0;
      for (int c = 0; c < 7; c++) step(6'(op), 1'b1);
      // R4 R5 R3: after seven cycles every path has returned through fetch
    end
    // R1: reset in the middle of a load sequence
    rst = 1'b0;
    step(6'd35, 1'b0);
    while (exp_st != 3'd5) step(6'd35, 1'b0);
    #2 rst = 1'b1;
    step(6'd35, 1'b0);
    chk_state("R1", 3'd0);
    #2 rst = 1'b0;
    // R12: opcode at a non-decode edge does not steer the sequence
    while (exp_st != 3'd2) step(6'd43, 1'b0);
    step(6'd35, 1'b0);
    chk_state("R4", 3'd3);
    step(6'd35, 1'b0);
    chk_state("R4", 3'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule